// File: doc/BRIEF.md
# Shadow-Buffered Reloading Counter Timer

The block is a general-purpose counter timer for a larger chip. A free-running prescaler divides the clock. The divided ticks drive a counter that runs either upward from zero to a period value, or downward from the period value to zero. Software writes the division ratio and the period into buffer registers. The buffered values reach the active copies that the counting logic uses only at an update event, so a running period is never cut short by a reprogramming. A control bit can instead make period writes act at once.

An update event happens when the counter wraps in either direction, or one cycle after software writes the force bit. Each update event does four things:
- reloads the counter;
- clears the prescaler;
- loads the active copies from the buffers;
- raises a sticky update flag.

A control bit can keep software-forced updates from raising the flag. The interrupt output is the flag gated by an enable bit. Software reads the registers through a simple port with one cycle of read latency.

Top module: `upd_timer`

## Requirements
- R1: After a synchronous reset, the counter, all registers, the update flag and the interrupt output are 0.
- R2: While count enable is high, the counter advances once every (active divider + 1) clock cycles. An update event clears the prescaler, so the first tick after it comes (active divider + 1) enabled cycles later.
- R3: When the direction input is 0, each tick increments the counter. A tick that finds the counter equal to the active period sets the counter to 0 and is an update event.
- R4: When the direction input is 1, each tick decrements the counter. A tick that finds the counter at 0 loads the period buffer value into the counter and is an update event.
- R5: A write to the divider register (address 1) changes only its buffer. The active divider takes the buffer value at the next update event.
- R6: While config bit 0 is 1, a write to the period register (address 2) changes only its buffer, and the active period keeps its value until an update event. At a wrap-triggered update, the new value governs the very next period.
- R7: While config bit 0 is 0, a write to the period register also takes effect in the active period in the same cycle.
- R8: Writing data bit 0 = 1 to the force register (address 5) causes an update event on the following cycle. That event sets the counter to 0 when counting up and to the period buffer value when counting down. The force request is held for that one cycle only.
- R9: Every update event sets the update flag. The exception is a forced update while config bit 1 is 1, which leaves the flag unchanged. Wrap-triggered updates still set the flag while config bit 1 is 1.
- R10: Writing 1 to data bit 0 of the status register (address 3) clears the flag, and writing 0 there has no effect. If a set and a clear occur in the same cycle, the set wins.
- R11: The interrupt output equals the update flag ANDed with config bit 2, and changes in the same cycle as the flag.
- R12: Register reads return data one cycle after the address is presented. The map is: address 0 config, 1 divider buffer, 2 period buffer, 3 flag in bit 0, 4 counter, other addresses 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | DATA_W | Registered read data |
| cnt_en_i | input | 1 | Count enable for the prescaler and counter |
| dir_down_i | input | 1 | Count direction, 1 = down |
| upd_flag_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The in-RTL properties check, on every cycle:
- the prescaler stays within its active ratio and is cleared by each update;
- the counter holds between ticks, and it lands on 0 after an upward wrap or on the period buffer after a downward wrap;
- a buffered period stays stable between updates;
- the force request drops after one cycle;
- a suppressed forced update leaves the flag low;
- an interrupt never rises without the flag.

Only the bench scenarios can show the end-to-end arithmetic. This covers the counter values after a given number of enabled cycles for various dividers, periods and directions. It also covers the difference between buffered and immediate period writes across a wrap, and a divider change that waits for an update before it applies.

// File: rtl/upd_timer_pkg.sv
package upd_timer_pkg;
  typedef logic [2:0] reg_addr_t;

  localparam reg_addr_t ADDR_CFG    = 3'd0;
  localparam reg_addr_t ADDR_DIV    = 3'd1;
  localparam reg_addr_t ADDR_PERIOD = 3'd2;
  localparam reg_addr_t ADDR_STATUS = 3'd3;
  localparam reg_addr_t ADDR_COUNT  = 3'd4;
  localparam reg_addr_t ADDR_FORCE  = 3'd5;

  localparam int CFG_BUF_BIT  = 0;
  localparam int CFG_QUIET_BIT = 1;
  localparam int CFG_IE_BIT   = 2;
  localparam int CFG_W        = 3;

  typedef struct packed {
    logic irq_en;
    logic quiet_sw;
    logic period_buf;
  } cfg_t;
endpackage

// File: rtl/upd_timer_presc.sv
module upd_timer_presc #(
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             upd_i,
  input  logic [PSC_W-1:0] div_act_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_cnt_q;

  assign tick_o = en_i && (div_cnt_q == div_act_i);

  always_ff @(posedge clk_i) begin
    if (rst_i)       div_cnt_q <= '0;
    else if (upd_i)  div_cnt_q <= '0;
    else if (tick_o) div_cnt_q <= '0;
    else if (en_i)   div_cnt_q <= div_cnt_q + 1'b1;
  end

  // R2: prescaler never passes its active ratio
  p_div_bound_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    div_cnt_q <= div_act_i);
  // R2: update event clears the prescaler
  p_div_clear_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    upd_i |=> (div_cnt_q == '0));
endmodule

// File: rtl/upd_timer_cnt.sv
module upd_timer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             down_i,
  input  logic             upd_i,
  input  logic [CNT_W-1:0] period_act_i,
  input  logic [CNT_W-1:0] period_nxt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (down_i ? (cnt_q == '0) : (cnt_q == period_act_i));

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (upd_i)  cnt_q <= down_i ? period_nxt_i : '0;
    else if (tick_i) cnt_q <= down_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
  end

  // R3: upward wrap lands on zero
  p_wrap_up_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (wrap_o && !down_i) |=> (cnt_q == '0));
  // R4: downward wrap reloads the period buffer value
  p_wrap_down_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (wrap_o && down_i) |=> (cnt_q == $past(period_nxt_i)));
  // R2: no tick and no update means the counter holds
  p_hold_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!tick_i && !upd_i) |=> $stable(cnt_q));
endmodule

// File: rtl/upd_timer_regs.sv
module upd_timer_regs
  import upd_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  reg_addr_t         wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  reg_addr_t         rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wrap_i,
  input  logic              upd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              force_o,
  output logic [PSC_W-1:0]  div_act_o,
  output logic [CNT_W-1:0]  period_act_o,
  output logic [CNT_W-1:0]  period_buf_o,
  output logic              flag_o,
  output logic              irq_o
);
  cfg_t             cfg_q, cfg_d;
  logic [PSC_W-1:0] div_buf_q, div_act_q;
  logic [CNT_W-1:0] per_buf_q, per_act_q;
  logic             force_q, flag_q, flag_d, irq_q;
  logic             wr_cfg, wr_div, wr_per, wr_clr, wr_force, flag_set;

  assign wr_cfg   = wr_en_i && (wr_addr_i == ADDR_CFG);
  assign wr_div   = wr_en_i && (wr_addr_i == ADDR_DIV);
  assign wr_per   = wr_en_i && (wr_addr_i == ADDR_PERIOD);
  assign wr_clr   = wr_en_i && (wr_addr_i == ADDR_STATUS) && wr_data_i[0];
  assign wr_force = wr_en_i && (wr_addr_i == ADDR_FORCE) && wr_data_i[0];

  assign cfg_d    = wr_cfg ? cfg_t'(wr_data_i[CFG_W-1:0]) : cfg_q;
  assign flag_set = wrap_i || (force_q && !cfg_q.quiet_sw);
  assign flag_d   = flag_set ? 1'b1 : (wr_clr ? 1'b0 : flag_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_q     <= '0;
      div_buf_q <= '0;
      div_act_q <= '0;
      per_buf_q <= '0;
      per_act_q <= '0;
      force_q   <= 1'b0;
      flag_q    <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      force_q <= wr_force;
      flag_q  <= flag_d;
      irq_q   <= flag_d && cfg_d.irq_en;
      if (wr_div) div_buf_q <= wr_data_i[PSC_W-1:0];
      if (wr_per) per_buf_q <= wr_data_i[CNT_W-1:0];
      if (upd_i) begin
        div_act_q <= div_buf_q;
        per_act_q <= per_buf_q;
      end
      if (wr_per && !cfg_q.period_buf) per_act_q <= wr_data_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rd_data_o <= '0;
    else begin
      case (rd_addr_i)
        ADDR_CFG:    rd_data_o <= DATA_W'(cfg_q);
        ADDR_DIV:    rd_data_o <= DATA_W'(div_buf_q);
        ADDR_PERIOD: rd_data_o <= DATA_W'(per_buf_q);
        ADDR_STATUS: rd_data_o <= DATA_W'(flag_q);
        ADDR_COUNT:  rd_data_o <= DATA_W'(cnt_i);
        default:     rd_data_o <= '0;
      endcase
    end
  end

  assign force_o      = force_q;
  assign div_act_o    = div_act_q;
  assign period_act_o = per_act_q;
  assign period_buf_o = per_buf_q;
  assign flag_o       = flag_q;
  assign irq_o        = irq_q;

  // R6: buffered period does not move between updates
  p_period_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (cfg_q.period_buf && !upd_i) |=> $stable(per_act_q));
  // R8: force request lasts a single cycle unless written again
  p_force_pulse_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (force_q && !wr_force) |=> !force_q);
  // R9: a suppressed forced update leaves a low flag low
  p_quiet_force_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (force_q && cfg_q.quiet_sw && !wrap_i && !flag_q) |=> !flag_q);
  // R11: interrupt only rises together with the flag
  p_irq_needs_flag_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(irq_q) |-> flag_q);
  // R10: a set wins over a simultaneous clear
  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag_set && wr_clr) |=> flag_q);
endmodule

// File: rtl/upd_timer.sv
module upd_timer
  import upd_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              cnt_en_i,
  input  logic              dir_down_i,
  output logic              upd_flag_o,
  output logic              irq_o
);
  logic             force_w, wrap_w, upd_w, tick_w;
  logic [PSC_W-1:0] div_act_w;
  logic [CNT_W-1:0] per_act_w, per_buf_w, cnt_w;

  assign upd_w = force_w || wrap_w;

  upd_timer_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W), .CNT_W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .wrap_i(wrap_w), .upd_i(upd_w), .cnt_i(cnt_w),
    .force_o(force_w), .div_act_o(div_act_w),
    .period_act_o(per_act_w), .period_buf_o(per_buf_w),
    .flag_o(upd_flag_o), .irq_o(irq_o)
  );

  upd_timer_presc #(.PSC_W(PSC_W)) u_presc (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(cnt_en_i), .upd_i(upd_w),
    .div_act_i(div_act_w), .tick_o(tick_w)
  );

  upd_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_w), .down_i(dir_down_i),
    .upd_i(upd_w), .period_act_i(per_act_w), .period_nxt_i(per_buf_w),
    .cnt_o(cnt_w), .wrap_o(wrap_w)
  );
endmodule

// File: tb/upd_timer_tb.sv
`timescale 1ns/1ps
module upd_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        cnt_en = 1'b0;
  logic        dir_down = 1'b0;
  logic        flag, irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  upd_timer u_dut (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cnt_en_i(cnt_en), .dir_down_i(dir_down), .upd_flag_o(flag), .irq_o(irq)
  );

  typedef struct packed {
    logic [7:0] div;
    logic [7:0] per;
    logic       down;
    logic [7:0] cycles;
    logic [7:0] exp_cnt;
    logic       exp_flag;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{8'd0, 8'd5, 1'b0, 8'd3,  8'd3, 1'b0},
    '{8'd0, 8'd5, 1'b0, 8'd6,  8'd0, 1'b1},
    '{8'd0, 8'd5, 1'b0, 8'd8,  8'd2, 1'b1},
    '{8'd1, 8'd4, 1'b0, 8'd7,  8'd3, 1'b0},
    '{8'd2, 8'd3, 1'b0, 8'd12, 8'd0, 1'b1},
    '{8'd0, 8'd5, 1'b1, 8'd2,  8'd3, 1'b0},
    '{8'd0, 8'd5, 1'b1, 8'd6,  8'd5, 1'b1},
    '{8'd3, 8'd2, 1'b1, 8'd9,  8'd0, 1'b0},
    '{8'd3, 8'd2, 1'b1, 8'd12, 8'd2, 1'b1},
    '{8'd0, 8'd0, 1'b0, 8'd4,  8'd0, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic run(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic force_upd();
    wr(3'd5, 16'd1);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 flag", flag, 0);
    chk("R1 irq", irq, 0);
    rd(3'd4, v); chk("R1 count", v, 0);
    rd(3'd0, v); chk("R1 cfg", v, 0);

    // vector table: buffered period, quiet forced updates
    for (int i = 0; i < NV; i++) begin
      dir_down = VEC[i].down;
      wr(3'd0, 16'd3);
      wr(3'd1, 16'(VEC[i].div));
      wr(3'd2, 16'(VEC[i].per));
      force_upd();
      wr(3'd3, 16'd1);
      rd(3'd4, v);
      chk("R8 forced reload", v, VEC[i].down ? int'(VEC[i].per) : 0);
      run(int'(VEC[i].cycles));
      rd(3'd4, v);
      if (VEC[i].down) chk("R4 R2 down count", v, int'(VEC[i].exp_cnt));
      else             chk("R3 R2 up count", v, int'(VEC[i].exp_cnt));
      chk("R9 wrap flag", flag, int'(VEC[i].exp_flag));
    end

    // R12 readback
    rd(3'd1, v); chk("R12 div read", v, 0);
    rd(3'd2, v); chk("R12 period read", v, 0);
    rd(3'd0, v); chk("R12 cfg read", v, 3);

    // R6 buffered period across an upward wrap
    dir_down = 1'b0;
    wr(3'd1, 16'd0); wr(3'd2, 16'd5); force_upd(); wr(3'd3, 16'd1);
    wr(3'd2, 16'd2);
    run(4);
    rd(3'd4, v); chk("R6 old period kept", v, 4);
    run(5);
    rd(3'd4, v); chk("R6 new period after wrap", v, 0);

    // R7 immediate period
    wr(3'd0, 16'd2);
    wr(3'd2, 16'd5); force_upd();
    wr(3'd2, 16'd2);
    run(4);
    rd(3'd4, v); chk("R7 immediate period", v, 1);

    // R6 R4 downward wrap uses new buffered period
    wr(3'd0, 16'd3);
    dir_down = 1'b1;
    wr(3'd2, 16'd3); force_upd();
    rd(3'd4, v); chk("R8 down reload", v, 3);
    wr(3'd2, 16'd6);
    run(4);
    rd(3'd4, v); chk("R6 R4 reload new period", v, 6);

    // R5 divider buffered until an update
    dir_down = 1'b0;
    wr(3'd1, 16'd0); wr(3'd2, 16'd100); force_upd();
    wr(3'd1, 16'd3);
    run(4);
    rd(3'd4, v); chk("R5 divider not yet active", v, 4);
    force_upd();
    run(8);
    rd(3'd4, v); chk("R5 R2 divider active", v, 2);

    // R9 R10 R11 flag and interrupt
    wr(3'd0, 16'd0);
    wr(3'd3, 16'd1);
    chk("R10 clear", flag, 0);
    force_upd();
    chk("R9 forced sets flag", flag, 1);
    chk("R11 irq masked", irq, 0);
    wr(3'd3, 16'd0);
    chk("R10 write zero ignored", flag, 1);
    rd(3'd3, v); chk("R12 status read", v, 1);
    wr(3'd0, 16'd4);
    chk("R11 irq enabled", irq, 1);
    wr(3'd0, 16'd6);
    wr(3'd3, 16'd1);
    chk("R10 cleared", flag, 0);
    chk("R11 irq follows flag", irq, 0);
    force_upd();
    chk("R9 quiet forced update", flag, 0);
    chk("R11 irq stays low", irq, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule